// File: doc/BRIEF.md
# Real-time resonant load emulator with Euler integration

This block stands in for a current-fed parallel resonant load so that a frequency tracking controller can be exercised without power hardware. The load is a coil modelled as a series resistance and inductance, with a capacitor across it. A current source feeds it through a four-switch bridge, and the bridge polarity follows the switching state. Two state variables are held: the load (capacitor) voltage and the coil current. Each emulation step advances them with a one-step forward Euler update.

A step has two strobes. The compute strobe evaluates every new state from the previous states only and holds the results as pending values. The update strobe then commits all pending states together. The current source, the state equations' coefficients (already multiplied by the step size) and all outputs are per-unit ones-complement words. In the intended scaling, the base current is 25 A, the base resistance is 10 Ω and the base voltage is their product. Full scale is fourteen times the DC-link current, which leaves room for a coil Q of 7 with a safety factor of 2.

The sign of the load voltage is also brought out as a square wave that can drive a phase tracker directly.

Top module: `rlc_load_emu`

## Requirements
- R1: While reset is high at a clock edge, all of v_load, i_coil, i_cap and i_inv become zero after that edge, and sq_out is 1.
- R2: Bridge code 2'b01 selects +i_dc, 2'b10 selects -i_dc, and 2'b00 or 2'b11 inject zero. The selected current appears on i_inv one cycle after a compute strobe.
- R3: A compute strobe evaluates i_cap = i_inv - i_coil, v' = v + k_cap*i_cap and i' = i + (k_ind*v - k_res*i) from the committed state before that edge. i_cap and i_inv show the result one cycle later.
- R4: An update strobe copies the pending v' and i' into v_load and i_coil one cycle later. Without an update strobe, v_load and i_coil hold their values, even when a compute strobe occurs.
- R5: When both strobes occur in the same cycle, the update commits the values pending before that cycle, and the compute uses the state from before that cycle.
- R6: Words are 16-bit ones complement, where a negative value is the bitwise inverse of its magnitude. The all-ones code on any input counts as zero, and no output ever carries the all-ones code.
- R7: Every sum and product saturates at +32767 (16'h7FFF) or -32767 (16'h8000) instead of wrapping.
- R8: A coefficient is unsigned with 12 fraction bits. A scaled value is floor(|x|*k/4096), with the sign of x.
- R9: sq_out is 1 when bit 15 of v_load is 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| calc_stb | input | 1 | Compute strobe: evaluate pending states |
| commit_stb | input | 1 | Update strobe: commit pending states |
| bridge_sw | input | 2 | Bridge state: bit 0 forward diagonal, bit 1 reverse diagonal |
| i_dc | input | 16 | DC-link current, ones complement |
| k_cap | input | 16 | Step size over capacitance, 4.12 unsigned |
| k_ind | input | 16 | Step size over inductance, 4.12 unsigned |
| k_res | input | 16 | Resistance times step size over inductance, 4.12 unsigned |
| v_load | output | 16 | Load voltage state |
| i_coil | output | 16 | Coil current state |
| i_cap | output | 16 | Capacitor current from the last compute |
| i_inv | output | 16 | Bridge current from the last compute |
| sq_out | output | 1 | Square wave from the load voltage sign |

## Verification
i_cap and i_inv are due one cycle after the edge that samples a compute strobe. v_load, i_coil and sq_out are due one cycle after the edge that samples an update strobe. The bench raises the strobes for exactly one cycle at a falling edge and compares all five outputs at the following falling edge, half a cycle after the register edge. Its model keeps the same split between pending and committed state, so it covers compute-only steps, update-only steps and the case where both strobes arrive together.

// File: rtl/rlc_emu_pkg.sv
package rlc_emu_pkg;

    localparam int unsigned DATA_W    = 16;
    localparam int unsigned COEF_W    = 16;
    localparam int unsigned COEF_FRAC = 12;
    localparam int unsigned MAG_W     = DATA_W - 1;
    localparam int unsigned PROD_W    = MAG_W + COEF_W;
    localparam int unsigned MSB       = DATA_W - 1;

    typedef logic [DATA_W-1:0] oc_t;
    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [MAG_W-1:0]  mag_t;

    localparam oc_t  OC_MAX  = {1'b0, {MAG_W{1'b1}}};
    localparam oc_t  OC_MIN  = {1'b1, {MAG_W{1'b0}}};
    localparam mag_t MAG_MAX = {MAG_W{1'b1}};

    typedef enum logic [1:0] {
        BR_OPEN  = 2'b00,
        BR_FWD   = 2'b01,
        BR_REV   = 2'b10,
        BR_SHORT = 2'b11
    } bridge_t;

    typedef struct packed {
        oc_t v;
        oc_t il;
    } tank_t;

    typedef struct packed {
        tank_t nxt;
        oc_t   ic;
        oc_t   ii;
    } step_t;

    typedef struct packed {
        coef_t kc;
        coef_t kl;
        coef_t kr;
    } coefs_t;

    // map the negative-zero code onto the positive zero
    function automatic oc_t oc_norm(oc_t x);
        return (&x) ? '0 : x;
    endfunction

    function automatic oc_t oc_neg(oc_t x);
        return oc_norm(~x);
    endfunction

    function automatic mag_t oc_mag(oc_t x);
        oc_t t;
        t = x[MSB] ? ~x : x;
        return t[MAG_W-1:0];
    endfunction

    function automatic oc_t oc_from_sm(logic neg, mag_t m);
        oc_t r;
        r = {1'b0, m};
        if (m == '0)
            return '0;
        return neg ? ~r : r;
    endfunction

    // ones-complement add with end-around carry and saturation
    function automatic oc_t oc_add(oc_t a, oc_t b);
        logic [DATA_W:0] s;
        oc_t r;
        s = {1'b0, a} + {1'b0, b};
        r = s[DATA_W-1:0] + oc_t'(s[DATA_W]);
        if ((a[MSB] == b[MSB]) && (r[MSB] != a[MSB]))
            r = a[MSB] ? OC_MIN : OC_MAX;
        return oc_norm(r);
    endfunction

    // signed value times unsigned fixed-point coefficient, truncated, saturated
    function automatic oc_t oc_scale(oc_t x, coef_t k);
        logic [PROD_W-1:0] p;
        logic [PROD_W-1:0] sh;
        mag_t m;
        p  = PROD_W'(oc_mag(x)) * PROD_W'(k);
        sh = p >> COEF_FRAC;
        m  = (sh > PROD_W'(MAG_MAX)) ? MAG_MAX : sh[MAG_W-1:0];
        return oc_from_sm(x[MSB], m);
    endfunction

endpackage

// File: rtl/rlc_bridge_src.sv
module rlc_bridge_src
    import rlc_emu_pkg::*;
(
    input  logic [1:0] sw,
    input  oc_t        i_dc,
    output oc_t        i_br
);
    bridge_t code;

    always_comb begin
        code = bridge_t'(sw);
        unique case (code)
            BR_FWD:  i_br = oc_norm(i_dc);
            BR_REV:  i_br = oc_neg(i_dc);
            default: i_br = '0;
        endcase
    end
endmodule

// File: rtl/rlc_euler_core.sv
module rlc_euler_core
    import rlc_emu_pkg::*;
(
    input  tank_t  prev,
    input  oc_t    i_br,
    input  coefs_t k,
    output step_t  res
);
    oc_t i_c;
    oc_t dv;
    oc_t v_drop;
    oc_t r_drop;
    oc_t di;

    always_comb begin
        // capacitor current: bridge current minus coil current
        i_c    = oc_add(i_br, oc_neg(prev.il));
        dv     = oc_scale(i_c, k.kc);
        // coil: L di/dt = v - R i
        v_drop = oc_scale(prev.v, k.kl);
        r_drop = oc_scale(prev.il, k.kr);
        di     = oc_add(v_drop, oc_neg(r_drop));

        res.nxt.v  = oc_add(prev.v, dv);
        res.nxt.il = oc_add(prev.il, di);
        res.ic     = i_c;
        res.ii     = i_br;
    end
endmodule

// File: rtl/rlc_step_regs.sv
module rlc_step_regs
    import rlc_emu_pkg::*;
#(
    parameter int unsigned NSTATE = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  calc,
    input  logic  commit,
    input  step_t res,
    output tank_t state,
    output oc_t   ic_q,
    output oc_t   ii_q
);
    oc_t nxt_w  [NSTATE];
    oc_t pend_q [NSTATE];
    oc_t st_q   [NSTATE];

    assign nxt_w[0] = res.nxt.v;
    assign nxt_w[1] = res.nxt.il;

    for (genvar g = 0; g < NSTATE; g++) begin : g_state
        // compute phase: pending from previous committed state
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[g] <= '0;
            else if (calc)
                pend_q[g] <= nxt_w[g];
        end
        // update phase: all states at once
        always_ff @(posedge clk) begin
            if (rst)
                st_q[g] <= '0;
            else if (commit)
                st_q[g] <= pend_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ic_q <= '0;
            ii_q <= '0;
        end else if (calc) begin
            ic_q <= res.ic;
            ii_q <= res.ii;
        end
    end

    assign state.v  = st_q[0];
    assign state.il = st_q[1];
endmodule

// File: rtl/rlc_load_emu.sv
module rlc_load_emu
    import rlc_emu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        calc_stb,
    input  logic        commit_stb,
    input  logic [1:0]  bridge_sw,
    input  logic [15:0] i_dc,
    input  logic [15:0] k_cap,
    input  logic [15:0] k_ind,
    input  logic [15:0] k_res,
    output logic [15:0] v_load,
    output logic [15:0] i_coil,
    output logic [15:0] i_cap,
    output logic [15:0] i_inv,
    output logic        sq_out
);
    oc_t    i_br;
    coefs_t k;
    tank_t  state;
    step_t  res;

    assign k.kc = k_cap;
    assign k.kl = k_ind;
    assign k.kr = k_res;

    rlc_bridge_src u_src (
        .sw   (bridge_sw),
        .i_dc (i_dc),
        .i_br (i_br)
    );

    rlc_euler_core u_core (
        .prev (state),
        .i_br (i_br),
        .k    (k),
        .res  (res)
    );

    rlc_step_regs #(.NSTATE(2)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .calc   (calc_stb),
        .commit (commit_stb),
        .res    (res),
        .state  (state),
        .ic_q   (i_cap),
        .ii_q   (i_inv)
    );

    assign v_load = state.v;
    assign i_coil = state.il;
    assign sq_out = ~state.v[MSB];
endmodule

// File: rtl/rlc_load_emu_chk.sv
module rlc_load_emu_chk (
    input logic        clk,
    input logic        rst,
    input logic        calc_stb,
    input logic        commit_stb,
    input logic [1:0]  bridge_sw,
    input logic [15:0] v_load,
    input logic [15:0] i_coil,
    input logic [15:0] i_cap,
    input logic [15:0] i_inv
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (v_load == 16'h0 && i_coil == 16'h0 && i_cap == 16'h0 && i_inv == 16'h0));

    assert_idle_bridge_R2: assert property (@(posedge clk) disable iff (rst)
        (calc_stb && (bridge_sw == 2'b00 || bridge_sw == 2'b11)) |=> (i_inv == 16'h0));

    assert_hold_state_R4: assert property (@(posedge clk) disable iff (rst)
        !commit_stb |=> ($stable(v_load) && $stable(i_coil)));

    assert_hold_pending_R3: assert property (@(posedge clk) disable iff (rst)
        !calc_stb |=> ($stable(i_cap) && $stable(i_inv)));

    assert_no_neg_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !(&v_load) && !(&i_coil) && !(&i_cap) && !(&i_inv));
endmodule

bind rlc_load_emu rlc_load_emu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .calc_stb   (calc_stb),
    .commit_stb (commit_stb),
    .bridge_sw  (bridge_sw),
    .v_load     (v_load),
    .i_coil     (i_coil),
    .i_cap      (i_cap),
    .i_inv      (i_inv)
);

// File: tb/tb_rlc_load_emu.sv
`timescale 1ns/1ps
module tb_rlc_load_emu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        calc_stb = 1'b0;
    logic        commit_stb = 1'b0;
    logic [1:0]  bridge_sw = 2'b00;
    logic [15:0] i_dc = '0;
    logic [15:0] k_cap = '0;
    logic [15:0] k_ind = '0;
    logic [15:0] k_res = '0;
    logic [15:0] v_load, i_coil, i_cap, i_inv;
    logic        sq_out;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    logic [15:0] m_v = '0, m_il = '0, p_v = '0, p_il = '0, p_ic = '0, p_ii = '0;

    always #10 clk = ~clk;

    rlc_load_emu dut (
        .clk(clk), .rst(rst), .calc_stb(calc_stb), .commit_stb(commit_stb),
        .bridge_sw(bridge_sw), .i_dc(i_dc), .k_cap(k_cap), .k_ind(k_ind), .k_res(k_res),
        .v_load(v_load), .i_coil(i_coil), .i_cap(i_cap), .i_inv(i_inv), .sq_out(sq_out)
    );

    function automatic longint o2i(logic [15:0] x);
        logic [15:0] t;
        t = ~x;
        return x[15] ? -longint'(t) : longint'(x);
    endfunction

    function automatic logic [15:0] i2o(longint v);
        longint c;
        logic [15:0] m;
        c = (v > 32767) ? 32767 : ((v < -32767) ? -32767 : v);
        if (c < 0) begin
            m = 16'(-c);
            return ~m;
        end
        return 16'(c);
    endfunction

    function automatic logic [15:0] scl(logic [15:0] x, logic [15:0] k);
        longint a, p;
        a = o2i(x);
        p = ((a < 0 ? -a : a) * longint'(k)) >>> 12;
        return i2o(a < 0 ? -p : p);
    endfunction

    function automatic logic [15:0] src(logic [1:0] sw, logic [15:0] idc);
        if (sw == 2'b01) return i2o(o2i(idc));
        if (sw == 2'b10) return i2o(-o2i(idc));
        return 16'h0;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " v_load R3"}, v_load, m_v);
        chk({tag, " i_coil R3"}, i_coil, m_il);
        chk({tag, " i_cap R3"}, i_cap, p_ic);
        chk({tag, " i_inv R2"}, i_inv, p_ii);
        chk({tag, " sq_out R9"}, {15'b0, sq_out}, {15'b0, ~m_v[15]});
    endtask

    // one strobe cycle; results sampled at the next falling edge
    task automatic step(bit c, bit u, string tag);
        logic [15:0] ii, ic, nv, di, nil;
        ii  = src(bridge_sw, i_dc);
        ic  = i2o(o2i(ii) - o2i(m_il));
        nv  = i2o(o2i(m_v) + o2i(scl(ic, k_cap)));
        di  = i2o(o2i(scl(m_v, k_ind)) - o2i(scl(m_il, k_res)));
        nil = i2o(o2i(m_il) + o2i(di));
        calc_stb = c;
        commit_stb = u;
        @(negedge clk);
        calc_stb = 1'b0;
        commit_stb = 1'b0;
        if (u) begin m_v = p_v; m_il = p_il; end
        if (c) begin p_v = nv; p_il = nil; p_ic = ic; p_ii = ii; end
        chk_all(tag);
    endtask

    initial begin
        #4_000_000;
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk_all("reset R1");
        chk("reset sq R1", {15'b0, sq_out}, 16'h1);
        rst = 1'b0;

        // R2: bridge codes
        i_dc = 16'd1000; k_cap = 16'h0200; k_ind = 16'h0100; k_res = 16'h0040;
        bridge_sw = 2'b01; step(1, 0, "fwd R2");
        chk("calc-only holds v R4", v_load, 16'h0);
        bridge_sw = 2'b10; step(1, 0, "rev R2");
        bridge_sw = 2'b11; step(1, 0, "short R2");
        bridge_sw = 2'b00; step(1, 0, "open R2");
        bridge_sw = 2'b01; step(1, 0, "fwd again R2");
        step(0, 1, "commit R4");
        step(0, 1, "recommit R4");
        // R5: both strobes together
        repeat (4) step(1, 1, "both R5");
        // R6: negative-zero input counts as zero
        i_dc = 16'hFFFF; bridge_sw = 2'b01; step(1, 0, "negzero fwd R6");
        chk("negzero i_inv R6", i_inv, 16'h0000);
        bridge_sw = 2'b10; step(1, 0, "negzero rev R6");
        i_dc = 16'h0000; step(1, 0, "zero rev R6");
        chk("zero rev i_inv R6", i_inv, 16'h0000);

        // R7: drive voltage into positive saturation
        i_dc = 16'h7FFF; bridge_sw = 2'b01; k_cap = 16'hFFFF; k_ind = 16'h0; k_res = 16'h0;
        repeat (4) begin step(1, 0, "sat calc R7"); step(0, 1, "sat commit R7"); end
        chk("positive saturation R7", v_load, 16'h7FFF);
        bridge_sw = 2'b10;
        repeat (6) begin step(1, 0, "nsat calc R7"); step(0, 1, "nsat commit R7"); end
        chk("negative saturation R7", v_load, 16'h8000);
        chk("negative sign sq R9", {15'b0, sq_out}, 16'h0);

        // R8 and R3: random operation
        for (int n = 0; n < 400; n++) begin
            logic [15:0] mag;
            bridge_sw = 2'($urandom_range(0, 3));
            mag = 16'($urandom_range(0, 6000));
            i_dc = ($urandom_range(0, 7) == 0) ? ~mag : mag;
            k_cap = 16'($urandom_range(0, 16'h1000));
            k_ind = 16'($urandom_range(0, 16'h0800));
            k_res = 16'($urandom_range(0, 16'h0400));
            case ($urandom_range(0, 3))
                0: step(1, 1, "rand both R5");
                1: step(0, 1, "rand commit R4");
                default: begin step(1, 0, "rand calc R8"); step(0, 1, "rand commit R3"); end
            endcase
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_v = '0; m_il = '0; p_v = '0; p_il = '0; p_ic = '0; p_ii = '0;
        chk_all("second reset R1");

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule